// File: doc/BRIEF.md
# Ethernet Pause Frame Receive Filter

This block sits beside a receive MAC datapath and watches the incoming frame stream, one byte per clock, with start-of-frame, end-of-frame and checksum-good markers. It recognises MAC control traffic in four independently enabled classes: global control, priority control, global pause and priority pause. Each class holds its own switches for checking the destination address (against a programmable unicast or multicast address), the source address, a per-class EtherType and the opcode. The two control classes take an inclusive opcode range. The two pause classes need one exact opcode.

For an accepted pause frame the block pulls out the pause quanta and raises one-cycle valid bits and held request bits over nine slots. Slots 0 to 7 serve the eight priorities and slot 8 serves a classic global pause. An optional wait-for-acknowledge mode holds each request until downstream pause logic acknowledges it. At every frame end the block also gives a one-cycle verdict telling the downstream path whether to drop the frame. Control frames are dropped unless forwarding is enabled. Frames that match no enabled class always pass.

Frame layout is big-endian. The destination address is in bytes 0-5, the source address in bytes 6-11, the EtherType in bytes 12-13 and the opcode in bytes 14-15. Bytes 16-17 hold the global pause quanta, or the priority enable vector. Bytes 18-33 hold the eight priority quanta, starting with priority 0.

Top module: `pause_rx_filter`

## Requirements
- R1: Class index 0 is global control, 1 is priority control, 2 is global pause and 3 is priority pause, each enabled by bit i of `cfgClassEn`. A class whose enable bit is 0 never matches, so it produces no pause output and no drop.
- R2: Destination check per class: with neither `cfgChkMcast[i]` nor `cfgChkUcast[i]` set, the destination address is ignored. Otherwise it must equal `cfgMcastDa` (if the multicast switch is on) or `cfgUcastDa` (if the unicast switch is on). Byte 0 of the frame is the most significant byte of the 48-bit value.
- R3: With `cfgChkSa[i]` set, bytes 6-11 must equal `cfgSa` for class i to match. With it clear, the source address is ignored.
- R4: With `cfgChkEtype[i]` set, bytes 12-13 must equal `cfgEtype[16*i +: 16]`. With it clear, the EtherType is ignored.
- R5: With `cfgChkOpcode[i]` set, a control class c (0 or 1) needs `cfgOpLo[16*c +: 16]` <= opcode <= `cfgOpHi[16*c +: 16]`, both bounds included. A pause class needs an exact match with `cfgOpExact[15:0]` (global pause) or `cfgOpExact[31:16]` (priority pause).
- R6: An accepted global pause frame sets `pauseValid` to 9'h100 and loads quanta slot 8 (`pauseQuanta[143:128]`) from bytes 16-17.
- R7: An accepted priority pause frame sets `pauseValid[k]` for each bit k of byte 17 that is 1, and loads slot k (`pauseQuanta[16*k +: 16]`) from bytes 18+2k and 19+2k. Other slots keep their value. When a frame matches both pause classes, the priority pause result wins and slot 8 stays unchanged.
- R8: `pauseValid` is high for exactly the one cycle after the clock edge that takes the end byte. Quanta slots change only in that cycle.
- R9: A frame is accepted only if `inFcsOk` is 1 with the end byte and the frame is at least MIN_LEN (64) bytes long. Otherwise it gives no valid, no request, no quanta change and no drop.
- R10: When `cfgWaitAck` is 1, request bit k rises together with valid bit k and stays high until a cycle in which `ackIn[k]` is 1. Acknowledge bits of other slots have no effect.
- R11: When `cfgWaitAck` is 0, `ackIn` is ignored and each request bit is high only for the cycle in which its valid bit is high.
- R12: `frameDone` pulses in the cycle after every end byte. `frameDrop` is 1 with it only when the frame was accepted, matched at least one enabled class, and `cfgFwdCtl` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A frame byte is present this cycle |
| inSof | input | 1 | This byte is byte 0 of a frame |
| inEof | input | 1 | This byte is the last byte of a frame |
| inFcsOk | input | 1 | Checksum of the frame is good, read with the end byte |
| inData | input | 8 | Frame byte |
| cfgClassEn | input | 4 | Class enables, index per R1 |
| cfgChkMcast | input | 4 | Per-class multicast destination check |
| cfgChkUcast | input | 4 | Per-class unicast destination check |
| cfgChkSa | input | 4 | Per-class source address check |
| cfgChkEtype | input | 4 | Per-class EtherType check |
| cfgChkOpcode | input | 4 | Per-class opcode check |
| cfgUcastDa | input | 48 | Unicast destination address |
| cfgMcastDa | input | 48 | Multicast destination address |
| cfgSa | input | 48 | Expected source address |
| cfgEtype | input | 64 | Four EtherType values, class i in bits 16i+15:16i |
| cfgOpLo | input | 32 | Opcode minimum for control classes 0 and 1 |
| cfgOpHi | input | 32 | Opcode maximum for control classes 0 and 1 |
| cfgOpExact | input | 32 | Exact opcode: global pause low half, priority pause high half |
| cfgWaitAck | input | 1 | Hold requests until acknowledged |
| cfgFwdCtl | input | 1 | 1 forwards control frames, 0 drops them |
| ackIn | input | 9 | Per-slot acknowledge |
| pauseValid | output | 9 | One-cycle per-slot valid |
| pauseReq | output | 9 | Per-slot pause request |
| pauseQuanta | output | 144 | Nine 16-bit quanta, slot k in bits 16k+15:16k |
| frameDone | output | 1 | One-cycle pulse after each end byte |
| frameDrop | output | 1 | Drop verdict, valid with frameDone |

## Verification
The hardest case to reach is a frame that satisfies several classes at once while only some of them are enabled. The verdict and the slot vector then depend on the enable pattern, on precedence and on the forward switch together. The stimulus covers this by sweeping every enable pattern and both forward settings for a frame aimed at each class. A further frame is made to match both pause classes by giving them the same opcode. Acceptance edges are reached by sending frames at exactly 63 and 64 bytes, by clearing the checksum flag on a full-length frame, and by sending opcodes that sit exactly on and just outside the range bounds.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  localparam int NUM_PRI  = 8;
  localparam int NUM_SLOT = NUM_PRI + 1;
  localparam int NUM_CLS  = 4;
  localparam int QW       = 16;

  // byte offsets of header fields inside a frame
  localparam int POS_SA   = 6;
  localparam int POS_ET   = 12;
  localparam int POS_OP   = 14;
  localparam int POS_W16  = 16;
  localparam int POS_PQ   = 18;
  localparam int POS_END  = POS_PQ + 2 * NUM_PRI;

  typedef enum logic [1:0] {
    CLS_GCTL   = 2'd0,
    CLS_PCTL   = 2'd1,
    CLS_GPAUSE = 2'd2,
    CLS_PPAUSE = 2'd3
  } cls_e;

  typedef struct packed {
    logic [47:0] da;
    logic [47:0] sa;
    logic [15:0] etype;
    logic [15:0] opcode;
    logic [15:0] word16;
  } hdr_t;

  typedef struct packed {
    logic                done;
    logic                drop;
    logic [NUM_SLOT-1:0] slotHit;
  } strobe_t;
endpackage

// File: rtl/pfr_datapath.sv
module pfr_datapath
  import pfr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic                   inSof,
  input  logic                   inEof,
  input  logic [7:0]             inData,
  input  strobe_t                st,
  input  logic                   cfgWaitAck,
  input  logic [NUM_SLOT-1:0]    ackIn,
  output hdr_t                   hdr,
  output logic [CNT_W-1:0]       curIdx,
  output logic [NUM_SLOT-1:0]    pauseValid,
  output logic [NUM_SLOT-1:0]    pauseReq,
  output logic [NUM_SLOT*QW-1:0] pauseQuanta,
  output logic                   frameDone,
  output logic                   frameDrop
);
  localparam logic [CNT_W-1:0] IDX_SA  = CNT_W'(POS_SA);
  localparam logic [CNT_W-1:0] IDX_ET  = CNT_W'(POS_ET);
  localparam logic [CNT_W-1:0] IDX_OP  = CNT_W'(POS_OP);
  localparam logic [CNT_W-1:0] IDX_W16 = CNT_W'(POS_W16);
  localparam logic [CNT_W-1:0] IDX_PQ  = CNT_W'(POS_PQ);

  logic [CNT_W-1:0]          byteCnt;
  hdr_t                      hdrQ;
  logic [NUM_PRI-1:0][QW-1:0] priQ;
  logic [NUM_SLOT-1:0]       validQ, reqQ;
  logic                      doneQ, dropQ;

  assign curIdx = inSof ? '0 : byteCnt;
  assign hdr    = hdrQ;

  // byte position counter, saturating, cleared by the end byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) byteCnt <= '0;
    else if (inValid) begin
      if (inEof)              byteCnt <= '0;
      else if (curIdx != '1)  byteCnt <= curIdx + 1'b1;
    end
  end

  // header field capture, big-endian shift-in at fixed offsets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hdrQ <= '0;
    else if (inValid) begin
      if (curIdx < IDX_SA)                          hdrQ.da     <= {hdrQ.da[39:0], inData};
      else if (curIdx < IDX_ET)                     hdrQ.sa     <= {hdrQ.sa[39:0], inData};
      else if (curIdx < IDX_OP)                     hdrQ.etype  <= {hdrQ.etype[7:0], inData};
      else if (curIdx < IDX_W16)                    hdrQ.opcode <= {hdrQ.opcode[7:0], inData};
      else if (curIdx < IDX_PQ)                     hdrQ.word16 <= {hdrQ.word16[7:0], inData};
    end
  end

  for (genvar k = 0; k < NUM_PRI; k++) begin : g_pq
    localparam logic [CNT_W-1:0] LO = CNT_W'(POS_PQ + 2 * k);
    logic [QW-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (inValid && (curIdx == LO || curIdx == LO + 1'b1)) q <= {q[7:0], inData};
    end
    assign priQ[k] = q;
  end

  // per-slot quanta holding registers
  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    logic [QW-1:0] src, q;
    if (i == NUM_PRI) begin : g_glb
      assign src = hdrQ.word16;
    end else begin : g_pri
      assign src = priQ[i];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (st.slotHit[i]) q <= src;
    end
    assign pauseQuanta[i*QW +: QW] = q;
  end

  // valid pulse, request hold and frame verdict
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      reqQ   <= '0;
      doneQ  <= 1'b0;
      dropQ  <= 1'b0;
    end else begin
      validQ <= st.slotHit;
      reqQ   <= st.slotHit | (cfgWaitAck ? (reqQ & ~ackIn) : '0);
      doneQ  <= st.done;
      dropQ  <= st.drop;
    end
  end

  assign pauseValid = validQ;
  assign pauseReq   = reqQ;
  assign frameDone  = doneQ;
  assign frameDrop  = dropQ;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (|validQ) |=> (validQ == '0)); // R8
  AST_VALID_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rstN)
    (|validQ) |-> doneQ); // R8
  AST_REQ_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    cfgWaitAck |=> (((reqQ | ~$past(reqQ) | $past(ackIn))) == '1)); // R10
  AST_REQ_AUTOCLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWaitAck |=> ((reqQ & ~validQ) == '0)); // R11
  AST_DROP_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    frameDrop |-> frameDone); // R12
endmodule

// File: rtl/pfr_control.sv
module pfr_control
  import pfr_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int CNT_W   = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic                   inEof,
  input  logic                   inFcsOk,
  input  logic [CNT_W-1:0]       curIdx,
  input  hdr_t                   hdr,
  input  logic [NUM_CLS-1:0]     cfgClassEn,
  input  logic [NUM_CLS-1:0]     cfgChkMcast,
  input  logic [NUM_CLS-1:0]     cfgChkUcast,
  input  logic [NUM_CLS-1:0]     cfgChkSa,
  input  logic [NUM_CLS-1:0]     cfgChkEtype,
  input  logic [NUM_CLS-1:0]     cfgChkOpcode,
  input  logic [47:0]            cfgUcastDa,
  input  logic [47:0]            cfgMcastDa,
  input  logic [47:0]            cfgSa,
  input  logic [NUM_CLS*QW-1:0]  cfgEtype,
  input  logic [2*QW-1:0]        cfgOpLo,
  input  logic [2*QW-1:0]        cfgOpHi,
  input  logic [2*QW-1:0]        cfgOpExact,
  input  logic                   cfgFwdCtl,
  output strobe_t                st
);
  localparam logic [CNT_W-1:0] LEN_LAST = CNT_W'(MIN_LEN - 1);

  logic [NUM_CLS-1:0] hit;
  logic               endByte, goodFrame;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic daOk, saOk, etOk, opOk;
    assign daOk = !(cfgChkMcast[c] || cfgChkUcast[c])
                || (cfgChkMcast[c] && hdr.da == cfgMcastDa)
                || (cfgChkUcast[c] && hdr.da == cfgUcastDa);
    assign saOk = !cfgChkSa[c] || hdr.sa == cfgSa;
    assign etOk = !cfgChkEtype[c] || hdr.etype == cfgEtype[c*QW +: QW];
    if (c < 2) begin : g_range
      assign opOk = !cfgChkOpcode[c]
                  || (hdr.opcode >= cfgOpLo[c*QW +: QW] && hdr.opcode <= cfgOpHi[c*QW +: QW]);
    end else begin : g_exact
      assign opOk = !cfgChkOpcode[c] || hdr.opcode == cfgOpExact[(c-2)*QW +: QW];
    end
    assign hit[c] = cfgClassEn[c] && daOk && saOk && etOk && opOk;
  end

  assign endByte   = inValid && inEof;
  assign goodFrame = endByte && inFcsOk && (curIdx >= LEN_LAST);

  always_comb begin
    st.done    = endByte;
    st.drop    = goodFrame && (|hit) && !cfgFwdCtl;
    st.slotHit = '0;
    if (goodFrame && hit[CLS_PPAUSE])
      st.slotHit = {1'b0, hdr.word16[NUM_PRI-1:0]};
    else if (goodFrame && hit[CLS_GPAUSE])
      st.slotHit[NUM_PRI] = 1'b1;
  end

  AST_SHORT_FRAME_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (endByte && curIdx < LEN_LAST) |-> (st.slotHit == '0 && !st.drop)); // R9
  AST_BAD_FCS_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (endByte && !inFcsOk) |-> (st.slotHit == '0 && !st.drop)); // R9
  AST_GLOBAL_SLOT_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    st.slotHit[NUM_PRI] |-> (st.slotHit[NUM_PRI-1:0] == '0)); // R7
  AST_DISABLED_NO_PRI: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgClassEn[CLS_PPAUSE]) |-> (st.slotHit[NUM_PRI-1:0] == '0)); // R1
  AST_HIT_NEEDS_END: assert property (@(posedge clk) disable iff (!rstN)
    (!endByte) |-> (st.slotHit == '0 && !st.drop)); // R8
endmodule

// File: rtl/pause_rx_filter.sv
module pause_rx_filter
  import pfr_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int CNT_W   = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic                   inSof,
  input  logic                   inEof,
  input  logic                   inFcsOk,
  input  logic [7:0]             inData,
  input  logic [NUM_CLS-1:0]     cfgClassEn,
  input  logic [NUM_CLS-1:0]     cfgChkMcast,
  input  logic [NUM_CLS-1:0]     cfgChkUcast,
  input  logic [NUM_CLS-1:0]     cfgChkSa,
  input  logic [NUM_CLS-1:0]     cfgChkEtype,
  input  logic [NUM_CLS-1:0]     cfgChkOpcode,
  input  logic [47:0]            cfgUcastDa,
  input  logic [47:0]            cfgMcastDa,
  input  logic [47:0]            cfgSa,
  input  logic [NUM_CLS*QW-1:0]  cfgEtype,
  input  logic [2*QW-1:0]        cfgOpLo,
  input  logic [2*QW-1:0]        cfgOpHi,
  input  logic [2*QW-1:0]        cfgOpExact,
  input  logic                   cfgWaitAck,
  input  logic                   cfgFwdCtl,
  input  logic [NUM_SLOT-1:0]    ackIn,
  output logic [NUM_SLOT-1:0]    pauseValid,
  output logic [NUM_SLOT-1:0]    pauseReq,
  output logic [NUM_SLOT*QW-1:0] pauseQuanta,
  output logic                   frameDone,
  output logic                   frameDrop
);
  strobe_t          strobes;
  hdr_t             hdr;
  logic [CNT_W-1:0] curIdx;

  pfr_control #(.MIN_LEN(MIN_LEN), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inEof(inEof), .inFcsOk(inFcsOk),
    .curIdx(curIdx), .hdr(hdr), .cfgClassEn(cfgClassEn), .cfgChkMcast(cfgChkMcast),
    .cfgChkUcast(cfgChkUcast), .cfgChkSa(cfgChkSa), .cfgChkEtype(cfgChkEtype),
    .cfgChkOpcode(cfgChkOpcode), .cfgUcastDa(cfgUcastDa), .cfgMcastDa(cfgMcastDa),
    .cfgSa(cfgSa), .cfgEtype(cfgEtype), .cfgOpLo(cfgOpLo), .cfgOpHi(cfgOpHi),
    .cfgOpExact(cfgOpExact), .cfgFwdCtl(cfgFwdCtl), .st(strobes)
  );

  pfr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inData(inData), .st(strobes), .cfgWaitAck(cfgWaitAck), .ackIn(ackIn),
    .hdr(hdr), .curIdx(curIdx), .pauseValid(pauseValid), .pauseReq(pauseReq),
    .pauseQuanta(pauseQuanta), .frameDone(frameDone), .frameDrop(frameDrop)
  );
endmodule

// File: tb/tb_pause_rx_filter.sv
module tb_pause_rx_filter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        inValid = 0, inSof = 0, inEof = 0, inFcsOk = 0;
  logic [7:0]  inData = 0;
  logic [3:0]  cfgClassEn, cfgChkMcast, cfgChkUcast, cfgChkSa, cfgChkEtype, cfgChkOpcode;
  logic [47:0] cfgUcastDa, cfgMcastDa, cfgSa;
  logic [63:0] cfgEtype;
  logic [31:0] cfgOpLo, cfgOpHi, cfgOpExact;
  logic        cfgWaitAck, cfgFwdCtl;
  logic [8:0]  ackIn;
  logic [8:0]  pauseValid, pauseReq;
  logic [143:0] pauseQuanta;
  logic        frameDone, frameDrop;

  pause_rx_filter dut (.*);

  int nChecks = 0, nErr = 0;
  bit finished = 0;
  logic [7:0]  fb [128];
  logic [15:0] curQ [8];
  logic [15:0] expQ [9];

  localparam logic [47:0] UC = 48'h0200_0000_0001;
  localparam logic [47:0] MC = 48'h0180_C200_0001;
  localparam logic [47:0] SA = 48'h0A0B_0C0D_0E0F;
  localparam logic [15:0] ET = 16'h8808;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mkFrame(input logic [47:0] da, input logic [47:0] sa, input logic [15:0] et,
                         input logic [15:0] op, input logic [15:0] w16, input int seed);
    for (int i = 0; i < 128; i++) fb[i] = 8'(i * 7 + seed);
    for (int b = 0; b < 6; b++) begin
      fb[b]     = da[47 - 8*b -: 8];
      fb[6 + b] = sa[47 - 8*b -: 8];
    end
    fb[12] = et[15:8];  fb[13] = et[7:0];
    fb[14] = op[15:8];  fb[15] = op[7:0];
    fb[16] = w16[15:8]; fb[17] = w16[7:0];
    for (int k = 0; k < 8; k++) begin
      curQ[k] = 16'h1000 + 16'(seed * 8 + k);
      fb[18 + 2*k] = curQ[k][15:8];
      fb[19 + 2*k] = curQ[k][7:0];
    end
  endtask

  // returns at the falling edge right after the edge that takes the end byte
  task automatic sendFrame(input int len, input bit fcs);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1; inSof = (i == 0); inEof = (i == len - 1);
      inFcsOk = fcs; inData = fb[i];
    end
    @(negedge clk);
    inValid = 0; inSof = 0; inEof = 0; inFcsOk = 0;
  endtask

  task automatic checkQuanta(input string tag);
    for (int i = 0; i < 9; i++) chk(tag, 32'(pauseQuanta[i*16 +: 16]), 32'(expQ[i]));
  endtask

  // send, check the end-of-frame cycle and the cycle after
  task automatic runFrame(input string tag, input int len, input bit fcs,
                          input logic [15:0] w16, input logic [8:0] expV, input bit expDrop);
    sendFrame(len, fcs);
    for (int k = 0; k < 8; k++) if (expV[k]) expQ[k] = curQ[k];
    if (expV[8]) expQ[8] = w16;
    chk({tag, " valid"}, 32'(pauseValid), 32'(expV));
    chk({tag, " done"}, 32'(frameDone), 32'd1);
    chk({tag, " drop"}, 32'(frameDrop), 32'(expDrop));
    if (!cfgWaitAck) chk({tag, " R11 req"}, 32'(pauseReq), 32'(expV));
    checkQuanta(tag);
    @(negedge clk);
    chk({tag, " R8 pulse ends"}, 32'(pauseValid), 32'd0);
    if (!cfgWaitAck) chk({tag, " R11 req clears"}, 32'(pauseReq), 32'd0);
  endtask

  task automatic setDefaults();
    cfgClassEn = 4'hF; cfgChkMcast = 4'hF; cfgChkUcast = 4'h0;
    cfgChkSa = 4'hF; cfgChkEtype = 4'hF; cfgChkOpcode = 4'hF;
    cfgUcastDa = UC; cfgMcastDa = MC; cfgSa = SA;
    cfgEtype = {ET, ET, ET, ET};
    cfgOpLo = {16'h0102, 16'h0002};
    cfgOpHi = {16'h01FF, 16'h0100};
    cfgOpExact = {16'h0101, 16'h0001};
    cfgWaitAck = 0; cfgFwdCtl = 1; ackIn = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    logic [15:0] ops [4];
    int seed;
    ops[0] = 16'h0010; ops[1] = 16'h0150; ops[2] = 16'h0001; ops[3] = 16'h0101;
    seed = 0;
    for (int i = 0; i < 9; i++) expQ[i] = '0;
    setDefaults();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("reset valid", 32'(pauseValid), 0);
    chk("reset req", 32'(pauseReq), 0);
    chk("reset done", 32'(frameDone), 0);
    checkQuanta("reset quanta");

    // R1 R5 R6 R7 R12: every enable pattern, every class, both forward settings
    for (int kind = 0; kind < 4; kind++)
      for (int en = 0; en < 16; en++)
        for (int fwd = 0; fwd < 2; fwd++) begin
          logic [15:0] w16;
          logic [8:0]  ev;
          bit hitK;
          seed++;
          cfgClassEn = 4'(en); cfgFwdCtl = fwd[0];
          w16 = (kind == 2) ? 16'h4000 + 16'(seed) : {8'h00, 8'hA5 ^ 8'(en * 17)};
          mkFrame(MC, SA, ET, ops[kind], w16, seed);
          hitK = en[kind];
          ev = '0;
          if (hitK && kind == 3) ev = {1'b0, w16[7:0]};
          if (hitK && kind == 2) ev = 9'h100;
          runFrame($sformatf("R1 R5 R6 R7 R12 kind%0d en%0h fwd%0d", kind, en, fwd),
                   64, 1'b1, w16, ev, hitK && !fwd[0]);
        end

    // R2 R3 R4: field switches, global pause class only
    setDefaults(); cfgClassEn = 4'b0100;
    seed++; mkFrame(UC, SA, ET, 16'h0001, 16'h0055, seed);
    runFrame("R2 ucast DA, mcast check only", 64, 1, 16'h0055, 9'h000, 0);
    cfgChkUcast = 4'b0100;
    seed++; mkFrame(UC, SA, ET, 16'h0001, 16'h0056, seed);
    runFrame("R2 ucast DA, ucast check on", 64, 1, 16'h0056, 9'h100, 0);
    cfgChkUcast = 0; cfgChkMcast = 0;
    seed++; mkFrame(48'h1234_5678_9ABC, SA, ET, 16'h0001, 16'h0057, seed);
    runFrame("R2 DA ignored", 64, 1, 16'h0057, 9'h100, 0);
    cfgChkMcast = 4'hF;
    seed++; mkFrame(MC, 48'h0A0B_0C0D_0E0E, ET, 16'h0001, 16'h0058, seed);
    runFrame("R3 SA mismatch", 64, 1, 16'h0058, 9'h000, 0);
    cfgChkSa = 0;
    runFrame("R3 SA ignored", 64, 1, 16'h0058, 9'h100, 0);
    cfgChkSa = 4'hF;
    seed++; mkFrame(MC, SA, 16'h8809, 16'h0001, 16'h0059, seed);
    runFrame("R4 etype mismatch", 64, 1, 16'h0059, 9'h000, 0);
    cfgChkEtype = 4'b1011;
    runFrame("R4 etype ignored", 64, 1, 16'h0059, 9'h100, 0);
    cfgChkEtype = 4'hF;
    cfgEtype[47:32] = 16'h8809;
    runFrame("R4 per-class etype", 64, 1, 16'h0059, 9'h100, 0);
    cfgEtype = {ET, ET, ET, ET};
    seed++; mkFrame(MC, SA, ET, 16'h0002, 16'h005A, seed);
    runFrame("R5 pause exact mismatch", 64, 1, 16'h005A, 9'h000, 0);
    cfgChkOpcode = 4'b1011;
    runFrame("R5 pause opcode ignored", 64, 1, 16'h005A, 9'h100, 0);

    // R5 control range bounds via drop verdict
    setDefaults(); cfgClassEn = 4'b0001; cfgFwdCtl = 0;
    for (int t = 0; t < 4; t++) begin
      logic [15:0] op;
      op = (t == 0) ? 16'h0001 : (t == 1) ? 16'h0002 : (t == 2) ? 16'h0100 : 16'h0101;
      seed++; mkFrame(MC, SA, ET, op, 16'h0000, seed);
      runFrame($sformatf("R5 range op %h", op), 64, 1, 16'h0000, 9'h000, (t == 1 || t == 2));
    end

    // R9 acceptance: length and checksum
    setDefaults(); cfgFwdCtl = 0;
    seed++; mkFrame(MC, SA, ET, 16'h0001, 16'hBEEF, seed);
    runFrame("R9 63 bytes", 63, 1, 16'hBEEF, 9'h000, 0);
    runFrame("R9 bad fcs", 64, 0, 16'hBEEF, 9'h000, 0);
    runFrame("R9 64 bytes", 64, 1, 16'hBEEF, 9'h100, 1);
    seed++; mkFrame(MC, SA, ET, 16'h0001, 16'hCAFE, seed);
    runFrame("R9 100 bytes", 100, 1, 16'hCAFE, 9'h100, 1);

    // R7 precedence: both pause classes match
    setDefaults(); cfgOpExact = {16'h0101, 16'h0101};
    seed++; mkFrame(MC, SA, ET, 16'h0101, 16'h0081, seed);
    runFrame("R7 priority wins", 64, 1, 16'h0081, 9'h081, 0);

    // R10 wait for acknowledge
    setDefaults(); cfgWaitAck = 1;
    seed++; mkFrame(MC, SA, ET, 16'h0001, 16'h0777, seed);
    runFrame("R10 global", 64, 1, 16'h0777, 9'h100, 0);
    repeat (5) @(negedge clk);
    chk("R10 req held", 32'(pauseReq), 32'h100);
    ackIn = 9'h0FF;
    @(negedge clk);
    chk("R10 other acks no effect", 32'(pauseReq), 32'h100);
    ackIn = 9'h100;
    @(negedge clk);
    ackIn = 0;
    chk("R10 req cleared by ack", 32'(pauseReq), 32'h000);
    seed++; mkFrame(MC, SA, ET, 16'h0101, 16'h0003, seed);
    runFrame("R10 priority", 64, 1, 16'h0003, 9'h003, 0);
    chk("R10 two reqs", 32'(pauseReq), 32'h003);
    ackIn = 9'h001;
    @(negedge clk);
    ackIn = 0;
    chk("R10 partial ack", 32'(pauseReq), 32'h002);

    // R11 no wait: ack ignored, req already cleared
    cfgWaitAck = 0;
    @(negedge clk);
    chk("R11 switch off clears", 32'(pauseReq), 32'h000);
    ackIn = 9'h1FF;
    seed++; mkFrame(MC, SA, ET, 16'h0001, 16'h0888, seed);
    runFrame("R11 ack ignored", 64, 1, 16'h0888, 9'h100, 0);
    ackIn = 0;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end
endmodule